// File: doc/BRIEF.md
# Transactional Line Conflict Detector

This block tracks, for every processor of a small shared-memory cluster, the cache lines that the current hardware transaction has read and written. Each processor has one tracking set. An entry in the set holds a line tag, a read flag and a write flag. A transactional access is checked against every other processor's set in the same cycle that it is presented. If it would conflict, the requester is held in a stall, and the processor that already owns the line carries on. The block re-evaluates a stalled requester every cycle. The requester proceeds as soon as the owner commits or is aborted.

Stalled requesters can end up waiting on each other in a ring. The block keeps a waits-for matrix across all processors and finds such rings within the same cycle. It breaks a ring by aborting the member with the highest ID: that processor's tracking set is cleared and its transaction ends. Transactions nest flat, so only the outermost end commits. A tracking set that has no room for a new line reports an overflow for that processor.

Top module: `txn_conflict_tracker`

## Requirements
- R1: Conflicts are tracked per line. Two addresses that differ only in their low OFFSET_W bits (5 by default) are the same line.
- R2: A transactional access is stalled in the same cycle it is presented (acc_stall=1, acc_grant=0) in two cases. The first is a write to a line that another in-transaction processor has read or written. The second is a read of a line that another in-transaction processor has written.
- R3: A transactional read of a line that other processors have only read is granted in the same cycle, with no stall.
- R4: A stalled requester that keeps its request stays stalled during the cycle in which the owner raises its outermost end. It is granted in the next cycle.
- R5: A processor whose line is requested by others is never stalled by them. Its own accesses to that line are granted while they wait.
- R6: Suppose stalled requesters form a cycle of waits. Then in the next cycle txn_abort is high for exactly one member of the cycle, the one with the highest ID, and only for one cycle. That member's lines are released, so a requester that was waiting on it is granted in that same next cycle.
- R7: Nesting is flat. A begin inside a transaction only raises the depth. An inner end keeps the recorded lines. Only the end that brings the depth back to zero releases them.
- R8: Each set holds ENTRIES (8) distinct lines. A transactional access to a new line when the set is full raises set_overflow with no grant, and the line is not recorded. An access to a line that is already recorded is still granted.
- R9: An access made outside a transaction is granted, is not checked against other sets, and is not recorded.
- R10: After reset no processor is in a transaction, and with no requests every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_begin | input | NPROC | Per-processor begin pulse (depth +1) |
| txn_end | input | NPROC | Per-processor end pulse (depth -1; commit at depth 1) |
| acc_valid | input | NPROC | Per-processor access request, held until granted |
| acc_write | input | NPROC | 1 = write access, 0 = read access |
| acc_addr | input | NPROC*ADDR_W | Byte addresses; processor p uses bits [p*ADDR_W +: ADDR_W] |
| acc_grant | output | NPROC | Access accepted this cycle |
| acc_stall | output | NPROC | Access conflicts and must be repeated |
| txn_abort | output | NPROC | One-cycle pulse: transaction aborted to break a wait cycle |
| set_overflow | output | NPROC | New line could not be recorded |

## Verification
The bench drives inputs just after a falling edge and samples 1 ns later. Grant, stall and overflow depend combinationally on the request and the current set contents, so they are checked in the same cycle as the request. Begin, end and recording take effect at the next rising edge. Checks that depend on them, such as a grant after a commit or a stall after an inner end, are therefore sampled one cycle after the pulse. The abort pulse is registered: it is checked one cycle after the cycle in which every member of the ring shows a stall, and it is checked low again one cycle later.

// File: rtl/txn_tracker_pkg.sv
package txn_tracker_pkg;

   // Per-entry state of a line tracking set
   typedef struct packed {
      logic vld;
      logic rd;
      logic wr;
   } line_flags_t;

endpackage

// File: rtl/txn_line_set.sv
module txn_line_set
   import txn_tracker_pkg::*;
#(
   parameter int NPROC   = 4,
   parameter int ENTRIES = 8,
   parameter int LINE_W  = 27
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    rec_en,
   input  logic                    rec_write,
   input  logic [LINE_W-1:0]       rec_line,
   input  logic [NPROC*LINE_W-1:0] probe_line,
   output logic [NPROC-1:0]        probe_any,
   output logic [NPROC-1:0]        probe_wr,
   output logic                    full
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 1) begin : g_bad_entries
      $error("txn_line_set: ENTRIES must be at least 1");
   end

   logic [LINE_W-1:0] tag_q [ENTRIES];
   line_flags_t       flg_q [ENTRIES];
   logic [ENTRIES-1:0] rec_match;
   logic [ENTRIES-1:0] vld_vec;
   logic [IDX_W-1:0]   free_idx;
   logic               free_found;

   always_comb begin
      free_idx   = '0;
      free_found = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
         vld_vec[e]   = flg_q[e].vld;
         rec_match[e] = flg_q[e].vld && (tag_q[e] == rec_line);
         if (!flg_q[e].vld && !free_found) begin
            free_idx   = IDX_W'(e);
            free_found = 1'b1;
         end
      end
   end
   assign full = ~free_found;

   for (genvar p = 0; p < NPROC; p++) begin : g_probe
      always_comb begin
         probe_any[p] = 1'b0;
         probe_wr[p]  = 1'b0;
         for (int e = 0; e < ENTRIES; e++) begin
            if (flg_q[e].vld && tag_q[e] == probe_line[p*LINE_W +: LINE_W]) begin
               probe_any[p] = 1'b1;
               probe_wr[p]  = probe_wr[p] | flg_q[e].wr;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         for (int e = 0; e < ENTRIES; e++) begin
            flg_q[e] <= '0;
            tag_q[e] <= '0;
         end
      end else if (rec_en) begin
         if (|rec_match) begin
            for (int e = 0; e < ENTRIES; e++) begin
               if (rec_match[e]) begin
                  flg_q[e].wr <= flg_q[e].wr | rec_write;
                  flg_q[e].rd <= flg_q[e].rd | ~rec_write;
               end
            end
         end else if (free_found) begin
            tag_q[free_idx] <= rec_line;
            flg_q[free_idx] <= '{vld: 1'b1, rd: ~rec_write, wr: rec_write};
         end
      end
   end

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (vld_vec == '0)); // R7

   AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
      (full && rec_en && !(|rec_match) && !clear) |=> $stable(vld_vec)); // R8
endmodule

// File: rtl/txn_wait_cycle.sv
module txn_wait_cycle #(
   parameter int NPROC = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPROC*NPROC-1:0] waits,
   output logic [NPROC-1:0]       victim
);
   logic [NPROC-1:0] reach [NPROC];
   logic [NPROC-1:0] on_cycle;
   logic [NPROC-1:0] waiting;

   // Transitive closure of the waits-for relation (row i: i waits on j)
   always_comb begin
      for (int i = 0; i < NPROC; i++) begin
         reach[i]   = waits[i*NPROC +: NPROC];
         waiting[i] = |waits[i*NPROC +: NPROC];
      end
      for (int k = 0; k < NPROC; k++) begin
         for (int i = 0; i < NPROC; i++) begin
            for (int j = 0; j < NPROC; j++) begin
               reach[i][j] = reach[i][j] | (reach[i][k] & reach[k][j]);
            end
         end
      end
      victim = '0;
      for (int i = 0; i < NPROC; i++) begin
         on_cycle[i] = reach[i][i];
         if (reach[i][i]) victim = NPROC'(1) << i;
      end
   end

   for (genvar i = 0; i < NPROC; i++) begin : g_chk
      AST_VICTIM_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
         victim[i] |-> waiting[i]); // R6
   end
endmodule

// File: rtl/txn_conflict_tracker.sv
module txn_conflict_tracker #(
   parameter int NPROC    = 4,
   parameter int ENTRIES  = 8,
   parameter int ADDR_W   = 32,
   parameter int OFFSET_W = 5,
   parameter int DEPTH_W  = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPROC-1:0]        txn_begin,
   input  logic [NPROC-1:0]        txn_end,
   input  logic [NPROC-1:0]        acc_valid,
   input  logic [NPROC-1:0]        acc_write,
   input  logic [NPROC*ADDR_W-1:0] acc_addr,
   output logic [NPROC-1:0]        acc_grant,
   output logic [NPROC-1:0]        acc_stall,
   output logic [NPROC-1:0]        txn_abort,
   output logic [NPROC-1:0]        set_overflow
);
   localparam int LINE_W = ADDR_W - OFFSET_W;

   if (NPROC < 2) begin : g_bad_nproc
      $error("txn_conflict_tracker: NPROC must be at least 2");
   end
   if (OFFSET_W >= ADDR_W) begin : g_bad_offset
      $error("txn_conflict_tracker: OFFSET_W must be below ADDR_W");
   end
   if (DEPTH_W < 1) begin : g_bad_depth
      $error("txn_conflict_tracker: DEPTH_W must be at least 1");
   end

   logic [DEPTH_W-1:0]      depth_q [NPROC];
   logic [NPROC-1:0]        in_txn;
   logic [NPROC-1:0]        commit;
   logic [NPROC-1:0]        victim;
   logic [NPROC-1:0]        set_full;
   logic [NPROC*LINE_W-1:0] lines;
   logic [NPROC-1:0]        hit_any [NPROC];
   logic [NPROC-1:0]        hit_wr  [NPROC];
   logic [NPROC*NPROC-1:0]  waits;

   for (genvar i = 0; i < NPROC; i++) begin : g_proc
      assign lines[i*LINE_W +: LINE_W] = acc_addr[i*ADDR_W + OFFSET_W +: LINE_W];
      assign in_txn[i] = (depth_q[i] != '0);
      assign commit[i] = txn_end[i] && !txn_begin[i] && (depth_q[i] == DEPTH_W'(1));

      // Row i of the waits-for matrix
      for (genvar j = 0; j < NPROC; j++) begin : g_pair
         if (i == j) begin : g_self
            assign waits[i*NPROC + j] = 1'b0;
         end else begin : g_other
            assign waits[i*NPROC + j] = acc_valid[i] && in_txn[i] &&
               (hit_wr[j][i] || (acc_write[i] && hit_any[j][i]));
         end
      end

      assign acc_stall[i]    = |waits[i*NPROC +: NPROC];
      assign set_overflow[i] = acc_valid[i] && in_txn[i] && !acc_stall[i] &&
                               !hit_any[i][i] && set_full[i];
      assign acc_grant[i]    = acc_valid[i] && !acc_stall[i] && !set_overflow[i];

      txn_line_set #(.NPROC(NPROC), .ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_set (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (victim[i] | commit[i]),
         .rec_en    (acc_grant[i] & in_txn[i]),
         .rec_write (acc_write[i]),
         .rec_line  (lines[i*LINE_W +: LINE_W]),
         .probe_line(lines),
         .probe_any (hit_any[i]),
         .probe_wr  (hit_wr[i]),
         .full      (set_full[i])
      );

      always_ff @(posedge clk) begin
         if (!rst_n || victim[i]) begin
            depth_q[i] <= '0;
         end else if (txn_begin[i] && !txn_end[i]) begin
            if (depth_q[i] != '1) depth_q[i] <= depth_q[i] + DEPTH_W'(1);
         end else if (txn_end[i] && !txn_begin[i] && in_txn[i]) begin
            depth_q[i] <= depth_q[i] - DEPTH_W'(1);
         end
      end

      AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         txn_abort[i] |=> !txn_abort[i]); // R6
      AST_ABORT_ENDS_TXN: assert property (@(posedge clk) disable iff (!rst_n)
         txn_abort[i] |-> !in_txn[i]); // R6
      AST_TXN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(in_txn[i]) |-> (txn_abort[i] || $past(txn_end[i]))); // R7
      AST_OWNER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
         (acc_valid[i] && !in_txn[i]) |-> acc_grant[i]); // R9
   end

   txn_wait_cycle #(.NPROC(NPROC)) u_cycle (
      .clk   (clk),
      .rst_n (rst_n),
      .waits (waits),
      .victim(victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) txn_abort <= '0;
      else        txn_abort <= victim;
   end
endmodule

// File: tb/txn_conflict_tracker_bench.sv
`timescale 1ns/1ps
module txn_conflict_tracker_bench;
   localparam int NP = 4;
   localparam int AW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NP-1:0]    tb_begin, tb_end, tb_valid, tb_write;
   logic [NP*AW-1:0] tb_addr;
   logic [NP-1:0]    grant, stall, abort_o, ovf;
   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   txn_conflict_tracker u_txn_conflict_tracker (
      .clk(clk), .rst_n(rst_n), .txn_begin(tb_begin), .txn_end(tb_end),
      .acc_valid(tb_valid), .acc_write(tb_write), .acc_addr(tb_addr),
      .acc_grant(grant), .acc_stall(stall), .txn_abort(abort_o),
      .set_overflow(ovf));

   task automatic chk(string req, logic [NP-1:0] act, logic [NP-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic idle();
      tb_begin = '0; tb_end = '0; tb_valid = '0; tb_write = '0; tb_addr = '0;
   endtask

   task automatic acc(int p, logic [AW-1:0] a, logic w);
      tb_valid[p] = 1'b1; tb_write[p] = w; tb_addr[p*AW +: AW] = a;
   endtask

   task automatic drop(int p);
      tb_valid[p] = 1'b0; tb_write[p] = 1'b0;
   endtask

   // advance past one rising edge; returns just after the falling edge
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic pulse_begin(logic [NP-1:0] m);
      tb_begin = m; tick(); tb_begin = '0;
   endtask

   task automatic pulse_end(logic [NP-1:0] m);
      tb_end = m; tick(); tb_end = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      idle();
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      settle();
      // R10: reset state
      chk("R10 grant", grant, '0);
      chk("R10 stall", stall, '0);
      chk("R10 abort", abort_o, '0);
      chk("R10 overflow", ovf, '0);

      // R1..R5: sweep over every ordered pair and every read/write mix
      for (int i = 0; i < NP; i++) begin
         for (int j = 0; j < NP; j++) begin
            if (i == j) continue;
            for (int ow = 0; ow < 2; ow++) begin
               for (int rw = 0; rw < 2; rw++) begin
                  logic [AW-1:0] base;
                  logic expst;
                  base  = 32'h1000 + ((i*NP + j) << 5);
                  expst = (ow != 0) || (rw != 0);
                  pulse_begin((NP'(1) << i) | (NP'(1) << j));
                  acc(j, base + 4, ow[0]);
                  settle();
                  chk("R5 owner first access", grant[j], 1'b1);
                  tick(); idle();
                  acc(j, base + 8, 1'b0);
                  acc(i, base + 28, rw[0]);   // same line, other offset (R1)
                  settle();
                  chk(expst ? "R2 conflict stall" : "R3 shared read", stall[i], expst);
                  chk("R1 line grant", grant[i], !expst);
                  chk("R5 owner runs", grant[j], 1'b1);
                  tick();
                  drop(j);
                  if (expst) begin
                     tb_end[j] = 1'b1;
                     settle();
                     chk("R4 stall during owner end", stall[i], 1'b1);
                     tick(); tb_end[j] = 1'b0;
                     settle();
                     chk("R4 grant after commit", grant[i], 1'b1);
                     chk("R6 no abort without cycle", abort_o, '0);
                     tick(); idle();
                     pulse_end(NP'(1) << i);
                  end else begin
                     drop(i);
                     pulse_end(NP'(1) << j);
                     pulse_end(NP'(1) << i);
                  end
               end
            end
         end
      end

      // R6: two-party wait cycles, every pair
      for (int i = 0; i < NP; i++) begin
         for (int j = i + 1; j < NP; j++) begin
            idle();
            pulse_begin((NP'(1) << i) | (NP'(1) << j));
            acc(i, 32'h4000, 1'b1); acc(j, 32'h4020, 1'b1);
            tick(); idle();
            acc(i, 32'h4020, 1'b0); acc(j, 32'h4000, 1'b0);
            settle();
            chk("R2 both stalled", stall, (NP'(1) << i) | (NP'(1) << j));
            chk("R6 no abort yet", abort_o, '0);
            tick(); drop(j);
            settle();
            chk("R6 highest id aborted", abort_o, NP'(1) << j);
            chk("R6 survivor granted", grant[i], 1'b1);
            tick(); idle();
            settle();
            chk("R6 abort is one pulse", abort_o, '0);
            pulse_end(NP'(1) << i);
         end
      end

      // R6: three-party cycle 0->1->2->0
      idle();
      pulse_begin(4'b0111);
      acc(0, 32'h8000, 1'b1); acc(1, 32'h8020, 1'b1); acc(2, 32'h8040, 1'b1);
      tick(); idle();
      acc(0, 32'h8020, 1'b0); acc(1, 32'h8040, 1'b0); acc(2, 32'h8000, 1'b0);
      settle();
      chk("R2 ring stalled", stall, 4'b0111);
      tick(); drop(2);
      settle();
      chk("R6 ring victim", abort_o, 4'b0100);
      chk("R6 waiter on victim granted", grant[1], 1'b1);
      chk("R6 other waiter still stalled", stall[0], 1'b1);
      tick(); drop(1);
      tb_end[1] = 1'b1;
      settle();
      chk("R4 stalled through end cycle", stall[0], 1'b1);
      tick(); tb_end[1] = 1'b0;
      settle();
      chk("R4 granted after commit", grant[0], 1'b1);
      tick(); idle();
      pulse_end(4'b0001);

      // R7: flat nesting
      pulse_begin(4'b0001);
      pulse_begin(4'b0001);
      acc(0, 32'h5000, 1'b1); tick(); idle();
      pulse_begin(4'b0010);
      pulse_end(4'b0001);
      acc(1, 32'h5010, 1'b0);
      settle();
      chk("R7 inner end keeps lines", stall[1], 1'b1);
      tb_end[0] = 1'b1;
      tick(); tb_end[0] = 1'b0;
      settle();
      chk("R7 outer end releases", grant[1], 1'b1);
      tick(); idle();
      pulse_end(4'b0010);

      // R8: set capacity
      pulse_begin(4'b0001);
      for (int k = 0; k < 8; k++) begin
         acc(0, 32'h2000 + k*32, 1'b1);
         settle();
         chk("R8 fill grant", grant[0], 1'b1);
         tick();
      end
      acc(0, 32'h2000 + 8*32, 1'b1);
      settle();
      chk("R8 overflow raised", ovf[0], 1'b1);
      chk("R8 no grant on overflow", grant[0], 1'b0);
      tick();
      acc(0, 32'h2000 + 3*32 + 12, 1'b0);
      settle();
      chk("R8 recorded line granted", grant[0], 1'b1);
      chk("R8 no overflow on hit", ovf[0], 1'b0);
      tick(); idle();
      pulse_begin(4'b0010);
      acc(1, 32'h2000 + 8*32, 1'b0);
      settle();
      chk("R8 overflowed line not recorded", grant[1], 1'b1);
      tick(); idle();
      acc(1, 32'h2000 + 3*32, 1'b0);
      settle();
      chk("R8 recorded line still owned", stall[1], 1'b1);
      tick(); idle();
      pulse_end(4'b0011);

      // R9: accesses outside a transaction
      pulse_begin(4'b1000);
      acc(3, 32'h6000, 1'b1); tick(); idle();
      acc(2, 32'h6004, 1'b1);
      settle();
      chk("R9 unchecked outside txn", grant[2], 1'b1);
      chk("R9 no stall outside txn", stall[2], 1'b0);
      tick(); idle();
      pulse_end(4'b1000);
      acc(2, 32'h7000, 1'b1); tick(); idle();
      pulse_begin(4'b1000);
      acc(3, 32'h7000, 1'b1);
      settle();
      chk("R9 not recorded outside txn", grant[3], 1'b1);
      tick(); idle();
      pulse_end(4'b1000);
      settle();
      chk("R10 quiet at end", grant | stall | abort_o | ovf, '0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end
endmodule